// File: doc/BRIEF.md
# I2S Philips-Format Audio Transmitter

This block is the transmit side of a serial audio link that also generates the link clock. It derives the bit clock from the system clock by a fixed ratio, produces the word-select line and shifts channel samples onto the serial data line in the Philips I2S format. Every channel slot is 32 bit clocks wide, and a frame is one left slot followed by one right slot. Each bit goes out most significant bit first.

Software or a feeding engine writes sample data 16 bits at a time into a single holding register. A packing mode sets how these half-words make up a channel word. A 16-bit sample takes one write and is padded with sixteen zero bits. A 24-bit sample takes two writes, and only the upper byte of the second write is used. A 32-bit sample takes two full writes. Three status outputs report the link to the writer: an empty flag for the holding register, the channel that the next write belongs to, and a sticky underrun flag. The underrun flag is raised when the serializer needs data and none has been written.

Top module: `i2s_philips_tx`

## Requirements
- R1: With `mode` = 2'b00, one write supplies one channel, and the slot carries the 16 written bits followed by sixteen 0 bits.
- R2: With `mode` = 2'b01, the first write of a channel gives sample bits 23..8, and bits 15..8 of the second write give bits 7..0. Bits 7..0 of the second write are ignored, and the last 8 bits of the slot are 0.
- R3: With `mode` = 2'b10 (2'b11 behaves the same), two writes form a 32-bit word: the first write is the upper half and the second is the lower half.
- R4: Slots are sent MSB first, left slot then right slot. `ws` is 0 for left and 1 for right, and it changes level one bit clock before the MSB of the slot it selects.
- R5: `sd` and `ws` change only on a falling edge of `sck`. A receiver samples them on the rising edge.
- R6: `tx_empty` is 1 after reset and is cleared by an accepted write. It returns to 1 when the held half-word moves into the serializer. A write while `tx_empty` is 0 is ignored.
- R7: If the serializer needs a half-word and the holding register is empty, zeros are sent in its place and `underrun` goes to 1. The flag stays at 1 while `enable` is 1 and clears when `enable` is 0.
- R8: `ch_side` is 0 while the next accepted write belongs to the left channel and 1 for the right. It advances after each write in mode 2'b00 and after every second write in the other modes.
- R9: `sck` period is 2*HALF_DIV system clocks. While `enable` is 0, `sck`, `ws` and `sd` are 0 and all sequencing restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the link; 0 clears sequencing and flags |
| mode | input | 2 | Packing mode: 00 16-in-32, 01 24-in-32, 10/11 32-bit |
| wr_en | input | 1 | Write strobe for one half-word |
| wr_data | input | 16 | Half-word written |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| tx_empty | output | 1 | Holding register can take a write |
| ch_side | output | 1 | Channel of the next write |
| underrun | output | 1 | Sticky flag: data was needed but none was held |

## Verification
A wrong frame position shows as `ws` toggling at an offset other than one bit before the MSB, and as slot words that are rotated. Both are visible on the first slot after `enable` rises. A wrong packing or half-word selection corrupts the received word within the slot where it occurs, either as wrong padding bits or as a dropped second byte. A holding flag that gets stuck or is overwritten shows as a write that should be ignored appearing on `sd`, or as `underrun` rising while data was written, at the next half-slot boundary, which is 16 bit clocks later.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    PK_16IN32 = 2'b00,
    PK_24IN32 = 2'b01,
    PK_32     = 2'b10,
    PK_32B    = 2'b11
  } pack_mode_e;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned SLOT_W = 32;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck       = sck_q;
  assign fall_tick = tick && sck_q;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_q); // R9
endmodule

// File: rtl/i2s_tx_frame.sv
module i2s_tx_frame #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fall_tick,
  output logic [$clog2(2*SLOT_W)-1:0] pos,
  output logic ws,
  output logic half_load,
  output logic second_half
);
  localparam int unsigned FRAME_W = 2 * SLOT_W;
  localparam int unsigned PW      = $clog2(FRAME_W);
  localparam int unsigned HB      = $clog2(HALF_W);
  localparam logic [PW-1:0] WS_HI_FIRST = PW'(SLOT_W - 1);
  localparam logic [PW-1:0] WS_HI_LAST  = PW'(FRAME_W - 2);

  logic [PW-1:0] pos_q, pos_d;
  logic          ws_q, ws_d;

  always_comb begin
    pos_d = pos_q;
    ws_d  = ws_q;
    if (!run) begin
      pos_d = '0;
      ws_d  = 1'b0;
    end else if (fall_tick) begin
      pos_d = pos_q + 1'b1;
      ws_d  = (pos_q >= WS_HI_FIRST) && (pos_q <= WS_HI_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ws_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      ws_q  <= ws_d;
    end
  end

  assign pos         = pos_q;
  assign ws          = ws_q;
  assign half_load   = fall_tick && (pos_q[HB-1:0] == '0);
  assign second_half = pos_q[HB];

  AST_WS_RISE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws_q) |-> (pos_q == PW'(SLOT_W))); // R4
  AST_WS_FALL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(ws_q)) |-> (pos_q == '0)); // R4
endmodule

// File: rtl/i2s_tx_feed.sv
module i2s_tx_feed
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  pack_mode_e        pmode,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              half_load,
  input  logic              second_half,
  output logic [HALF_W-1:0] half_word,
  output logic              tx_empty,
  output logic              ch_side,
  output logic              underrun
);
  localparam int unsigned BYTE_W = HALF_W / 2;

  logic [HALF_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              side_q, side_d;
  logic              wpart_q, wpart_d;
  logic              urun_q, urun_d;
  logic              need_hold, wr_acc, pad16, narrow;
  logic [HALF_W-1:0] src;

  assign pad16     = (pmode == PK_16IN32);
  assign narrow    = (pmode == PK_24IN32);
  assign need_hold = half_load && (!second_half || !pad16);
  assign wr_acc    = run && wr_en && !full_q;

  always_comb begin
    src = '0;
    if (need_hold && full_q) src = hold_q;
    if (narrow && second_half) src = {src[HALF_W-1:BYTE_W], {BYTE_W{1'b0}}};
  end

  always_comb begin
    hold_d  = hold_q;
    full_d  = full_q;
    side_d  = side_q;
    wpart_d = wpart_q;
    urun_d  = urun_q;
    if (!run) begin
      full_d  = 1'b0;
      side_d  = 1'b0;
      wpart_d = 1'b0;
      urun_d  = 1'b0;
    end else begin
      if (need_hold && full_q) full_d = 1'b0;
      if (need_hold && !full_q) urun_d = 1'b1;
      if (wr_acc) begin
        hold_d = wr_data;
        full_d = 1'b1;
        if (pad16) begin
          side_d = ~side_q;
        end else begin
          wpart_d = ~wpart_q;
          if (wpart_q) side_d = ~side_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      side_q  <= 1'b0;
      wpart_q <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      side_q  <= side_d;
      wpart_q <= wpart_d;
      urun_q  <= urun_d;
    end
  end

  assign half_word = src;
  assign tx_empty  = !full_q;
  assign ch_side   = side_q;
  assign underrun  = urun_q;

  AST_HOLD_KEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && full_q && wr_en) |=> $stable(hold_q)); // R6
  AST_TXE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && need_hold && full_q && !wr_en) |=> tx_empty); // R6
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_q && run) |=> urun_q); // R7
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fall_tick,
  input  logic              half_load,
  input  logic [HALF_W-1:0] half_word,
  output logic              sd
);
  logic [HALF_W-1:0] sh_q, sh_d;
  logic              sd_q, sd_d;

  always_comb begin
    sh_d = sh_q;
    sd_d = sd_q;
    if (!run) begin
      sh_d = '0;
      sd_d = 1'b0;
    end else if (fall_tick) begin
      if (half_load) begin
        sd_d = half_word[HALF_W-1];
        sh_d = {half_word[HALF_W-2:0], 1'b0};
      end else begin
        sd_d = sh_q[HALF_W-1];
        sh_d = {sh_q[HALF_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      sd_q <= sd_d;
    end
  end

  assign sd = sd_q;
endmodule

// File: rtl/i2s_philips_tx.sv
module i2s_philips_tx
  import i2s_tx_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  mode,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        sck,
  output logic        ws,
  output logic        sd,
  output logic        tx_empty,
  output logic        ch_side,
  output logic        underrun
);
  localparam int unsigned PW = $clog2(2 * SLOT_W);

  pack_mode_e        pmode;
  logic              fall_tick, half_load, second_half;
  logic [PW-1:0]     pos;
  logic [HALF_W-1:0] half_word;

  assign pmode = pack_mode_e'(mode);

  i2s_tx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(enable),
    .sck(sck), .fall_tick(fall_tick)
  );

  i2s_tx_frame #(.SLOT_W(SLOT_W), .HALF_W(HALF_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(enable), .fall_tick(fall_tick),
    .pos(pos), .ws(ws), .half_load(half_load), .second_half(second_half)
  );

  i2s_tx_feed u_feed (
    .clk(clk), .rst_n(rst_n), .run(enable), .pmode(pmode),
    .wr_en(wr_en), .wr_data(wr_data),
    .half_load(half_load), .second_half(second_half),
    .half_word(half_word), .tx_empty(tx_empty),
    .ch_side(ch_side), .underrun(underrun)
  );

  i2s_tx_shift #(.HALF_W(HALF_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(enable), .fall_tick(fall_tick),
    .half_load(half_load), .half_word(half_word), .sd(sd)
  );

  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(sd)) |-> ($past(sck) && !sck)); // R5
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(ws)) |-> ($past(sck) && !sck)); // R5
  AST_PAD16_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(fall_tick) && $past(pos[4])
     && (pmode == PK_16IN32) && $stable(mode)) |-> !sd); // R1
  AST_PAD24_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(fall_tick) && $past(pos[4:3] == 2'b11)
     && (pmode == PK_24IN32) && $stable(mode)) |-> !sd); // R2
endmodule

// File: tb/i2s_philips_tx_bench.sv
module i2s_philips_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic sck, ws, sd, tx_empty, ch_side, underrun;

  always #2.5 clk = ~clk;

  i2s_philips_tx #(.HALF_DIV(2)) u_i2s_philips_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .wr_en(wr_en), .wr_data(wr_data), .sck(sck), .ws(ws), .sd(sd),
    .tx_empty(tx_empty), .ch_side(ch_side), .underrun(underrun)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // feeder
  logic [15:0] wq [0:15];
  int nw = 0, wi = 0;
  bit feed_on = 0;
  initial forever begin
    @(negedge clk);
    if (feed_on && tx_empty && wi < nw) begin
      wr_en = 1'b1; wr_data = wq[wi]; wi++;
    end else if (feed_on) begin
      wr_en = 1'b0;
    end
  end

  // receiver model: samples on sck rising edges
  logic [31:0] rxw [0:7];
  int rx_n = 0, kbit = 0, ws_err = 0, edge_err = 0;
  bit seen_fall = 0;
  logic [31:0] cur = '0;
  logic p_sck = 0, p_sd = 0, p_ws = 0;
  initial forever begin
    @(negedge clk);
    if (!enable) begin
      seen_fall = 0; kbit = 0; rx_n = 0; cur = '0;
    end else begin
      if ((sd != p_sd || ws != p_ws) && !(p_sck && !sck)) edge_err++;
      if (p_sck && !sck) seen_fall = 1;
      if (!p_sck && sck && seen_fall) begin
        automatic int p = kbit % 64;
        automatic logic ews = (p >= 31) && (p != 63);
        cur = {cur[30:0], sd};
        if (ws != ews) ws_err++;
        if (p % 32 == 31 && rx_n < 8) begin rxw[rx_n] = cur; rx_n++; end
        kbit++;
      end
    end
    p_sck = sck; p_sd = sd; p_ws = ws;
  end

  task automatic wait_slots(input int n);
    for (int i = 0; i < 20000 && rx_n < n; i++) @(negedge clk);
  endtask

  task automatic stop_link();
    feed_on = 0;
    @(negedge clk); wr_en = 1'b0; enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(sck == 0 && ws == 0 && sd == 0, "R9 idle outputs", {29'd0, sck, ws, sd}, 0);
    chk(tx_empty == 1, "R6 empty after reset", tx_empty, 1);
    chk(underrun == 0 && ch_side == 0, "R7 R8 flags after reset",
        {30'd0, underrun, ch_side}, 0);
  endtask

  // mode m; writes given; expected words computed per mode
  task automatic run_stream(input logic [1:0] m, input int nwr, input int nslot,
                            input string tag);
    logic [31:0] ew;
    ws_err = 0; edge_err = 0;
    mode = m; nw = nwr; wi = 0;
    @(negedge clk); enable = 1'b1; feed_on = 1;
    wait_slots(nslot);
    for (int s = 0; s < nslot; s++) begin
      if (m == 2'b00) ew = {wq[s], 16'h0000};
      else if (m == 2'b01) ew = {wq[2*s], wq[2*s+1][15:8], 8'h00};
      else ew = {wq[2*s], wq[2*s+1]};
      chk(rxw[s] === ew, tag, rxw[s], ew);
    end
    chk(ws_err == 0, "R4 ws timing", ws_err, 0);
    chk(edge_err == 0, "R5 change on falling sck", edge_err, 0);
    chk(underrun == 0, "R7 no underrun when fed", underrun, 0);
    stop_link();
  endtask

  task automatic t_mode16();
    wq[0] = 16'h76A3; wq[1] = 16'h1234; wq[2] = 16'hABCD; wq[3] = 16'h8001;
    run_stream(2'b00, 4, 4, "R1 16-in-32 slot");
  endtask

  task automatic t_mode24();
    wq[0] = 16'h8EAA; wq[1] = 16'h33C5; wq[2] = 16'h1122; wq[3] = 16'hFFFF;
    wq[4] = 16'h8000; wq[5] = 16'h01A5; wq[6] = 16'h7FFF; wq[7] = 16'hFE5A;
    run_stream(2'b01, 8, 4, "R2 24-in-32 slot");
  endtask

  task automatic t_mode32();
    wq[0] = 16'hDEAD; wq[1] = 16'hBEEF; wq[2] = 16'h0123; wq[3] = 16'h4567;
    wq[4] = 16'hF00F; wq[5] = 16'h0FF1; wq[6] = 16'h8000; wq[7] = 16'h0001;
    run_stream(2'b10, 8, 4, "R3 32-bit slot");
  endtask

  task automatic t_underrun();
    mode = 2'b00;
    @(negedge clk); enable = 1'b1;
    wait_slots(2);
    chk(rxw[0] == 0 && rxw[1] == 0, "R7 zeros on underrun", rxw[0] | rxw[1], 0);
    chk(underrun == 1, "R7 underrun set", underrun, 1);
    repeat (50) @(negedge clk);
    chk(underrun == 1, "R7 underrun sticky", underrun, 1);
    stop_link();
    chk(underrun == 0, "R7 cleared by disable", underrun, 0);
  endtask

  task automatic t_chside();
    int w;
    mode = 2'b01;
    @(negedge clk); enable = 1'b1;
    wr_en = 1'b1; wr_data = 16'h8EAA;
    @(negedge clk); wr_en = 1'b0;
    chk(tx_empty == 0, "R6 write clears empty", tx_empty, 0);
    chk(ch_side == 0, "R8 side after first half", ch_side, 0);
    w = 0;
    while (!tx_empty && w < 200) begin @(negedge clk); w++; end
    chk(tx_empty == 1, "R6 empty after move", tx_empty, 1);
    wr_en = 1'b1; wr_data = 16'h33AA;
    @(negedge clk); wr_en = 1'b0;
    chk(ch_side == 1, "R8 side after second half", ch_side, 1);
    stop_link();
  endtask

  task automatic t_full_ignore();
    int w;
    mode = 2'b00;
    @(negedge clk); enable = 1'b1;
    wr_en = 1'b1; wr_data = 16'h1111;
    @(negedge clk); wr_data = 16'h2222;
    @(negedge clk); wr_en = 1'b0;
    w = 0;
    while (!tx_empty && w < 200) begin @(negedge clk); w++; end
    wr_en = 1'b1; wr_data = 16'h3333;
    @(negedge clk); wr_en = 1'b0;
    wait_slots(2);
    chk(rxw[0] == 32'h11110000, "R6 left slot", rxw[0], 32'h11110000);
    chk(rxw[1] == 32'h33330000, "R6 write while full ignored", rxw[1], 32'h33330000);
    stop_link();
  endtask

  task automatic t_sck_period();
    int c;
    mode = 2'b00;
    @(negedge clk); enable = 1'b1;
    while (!sck) @(negedge clk);
    c = 0;
    while (sck) begin @(negedge clk); c++; end
    while (!sck) begin @(negedge clk); c++; end
    chk(c == 4, "R9 sck period", c, 4);
    stop_link();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mode16();
    t_mode24();
    t_mode32();
    t_underrun();
    t_chside();
    t_full_ignore();
    t_sck_period();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule